// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by walking a two-level page table in memory. It takes one miss request at a time, carrying the faulting virtual address and the address-space identifier of the requester. The first-level table is found through a table base input. The walker reads one first-level entry. If that entry is present, it gives the location of a second-level table, and the walker reads one entry from it. If the leaf entry is present, the walker writes a translation into the TLB fill port and tells the requester to retry. If an entry is absent at either level, the walker raises a page fault together with the faulting address.

Memory is reached through a single word read port. The request side has valid and ready signals. The response side has a valid strobe with a data word. Only one read is in flight at any time. The walker stays busy from the moment it accepts a miss until it returns to idle. While it is busy, new misses are not taken.

Top module: `page_walker`

## Requirements
- R1: After reset the walker is idle. busy_o, mem_req_valid_o, fill_valid_o, retry_o and fault_o are all low.
- R2: A miss is accepted only when miss_valid_i is high while busy_o is low. busy_o rises on the next cycle and stays high until the walk ends. A miss presented while busy_o is high has no effect: no extra read, no extra fill or fault, and no change to the result of the current walk.
- R3: The first read goes to the table base plus four times the level-1 index, which is vaddr[31:22]. The table base is taken from base_i in the accepting cycle, so later changes to base_i do not affect the current walk.
- R4: A read request stays valid with an unchanged address until mem_req_ready_i is seen high.
- R5: The second read is issued only after the first response returns with its present bit set. Its address is {pte1[31:12], 12'h000} plus four times the level-2 index, which is vaddr[21:12].
- R6: If the leaf entry has bit 0 (present) set, fill_valid_o is high for exactly one cycle. That cycle is the one after the leaf response is taken. The fill carries vpn = vaddr[31:12], pfn = leaf[31:12], the identifier captured at acceptance, and global = leaf[8]. retry_o is high in exactly the same cycle.
- R7: If the level-1 entry has bit 0 clear, no second read is issued and no fill occurs. Instead, fault_o is high for one cycle, in the cycle after that response, with fault_vaddr_o equal to the full faulting address.
- R8: If the level-2 entry has bit 0 clear, no fill occurs. fault_o is high for one cycle, in the cycle after that response, with fault_vaddr_o equal to the faulting address.
- R9: Each walk ends in exactly one fill or exactly one fault, never both. busy_o is low in the following cycle, and the next miss can then be accepted.
- R10: A read request is raised only while busy_o is high. No new request is raised while a response is still awaited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| base_i | input | 32 | Physical address of the level-1 table |
| miss_valid_i | input | 1 | Miss request strobe |
| miss_vaddr_i | input | 32 | Faulting virtual address |
| miss_asid_i | input | 8 | Address-space identifier of the miss |
| busy_o | output | 1 | Walk in progress |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Read request accepted by memory |
| mem_req_addr_o | output | 32 | Byte address of the entry to read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Table entry read from memory |
| fill_valid_o | output | 1 | Translation write strobe |
| fill_vpn_o | output | 20 | Virtual page number of the fill |
| fill_pfn_o | output | 20 | Physical frame number of the fill |
| fill_asid_o | output | 8 | Identifier of the fill |
| fill_global_o | output | 1 | Global flag of the fill |
| retry_o | output | 1 | Requester should replay the access |
| fault_o | output | 1 | Page fault strobe |
| fault_vaddr_o | output | 32 | Faulting virtual address |

## Verification
The hardest situation to reach from the ports has two parts. A read request is held back by a memory that keeps ready low. During that wait, a second miss arrives and the table base moves. Both must leave the walk untouched. The bench's memory model withholds ready for several cycles and delays its response. While the first read is still pending, the bench pulses a second miss with a different address and changes base_i. It then checks that the read log, the fill fields and the fill count match only the original request. A level-2 fault needs a level-1 entry that is present and points at a second table, with a leaf that is absent. The bench builds both entries for each scenario and answers each read by matching the requested address.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int PRESENT_BIT = 0;
  localparam int GLOBAL_BIT  = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1_REQ,
    ST_L1_WAIT,
    ST_L2_REQ,
    ST_L2_WAIT,
    ST_FILL,
    ST_FAULT
  } walk_state_e;
endpackage

// File: rtl/pw_entry_addr.sv
module pw_entry_addr #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10
) (
  input  logic [ADDR_W-1:0] table_base_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] entry_addr_o
);
  localparam int PAD_W = ADDR_W - IDX_W - 2;

  // entries are 4-byte words
  assign entry_addr_o = table_base_i + {{PAD_W{1'b0}}, idx_i, 2'b00};
endmodule

// File: rtl/pw_pte_decode.sv
module pw_pte_decode #(
  parameter int PTE_W   = 32,
  parameter int OFF_W   = 12,
  parameter int PRES_B  = 0,
  parameter int GLOB_B  = 8
) (
  input  logic [PTE_W-1:0]       pte_i,
  output logic                   present_o,
  output logic                   global_o,
  output logic [PTE_W-OFF_W-1:0] pn_o
);
  assign present_o = pte_i[PRES_B];
  assign global_o  = pte_i[GLOB_B];
  assign pn_o      = pte_i[PTE_W-1:OFF_W];

  logic unused_flags;
  assign unused_flags = ^pte_i[OFF_W-1:0];
endmodule

// File: rtl/page_walker.sv
module page_walker
  import pw_pkg::*;
#(
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12,
  parameter int ASID_W = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [2*IDX_W+OFF_W-1:0]   base_i,
  input  logic                       miss_valid_i,
  input  logic [2*IDX_W+OFF_W-1:0]   miss_vaddr_i,
  input  logic [ASID_W-1:0]          miss_asid_i,
  output logic                       busy_o,
  output logic                       mem_req_valid_o,
  input  logic                       mem_req_ready_i,
  output logic [2*IDX_W+OFF_W-1:0]   mem_req_addr_o,
  input  logic                       mem_rsp_valid_i,
  input  logic [2*IDX_W+OFF_W-1:0]   mem_rsp_data_i,
  output logic                       fill_valid_o,
  output logic [2*IDX_W-1:0]         fill_vpn_o,
  output logic [2*IDX_W-1:0]         fill_pfn_o,
  output logic [ASID_W-1:0]          fill_asid_o,
  output logic                       fill_global_o,
  output logic                       retry_o,
  output logic                       fault_o,
  output logic [2*IDX_W+OFF_W-1:0]   fault_vaddr_o
);
  localparam int VA_W = 2*IDX_W + OFF_W;
  localparam int PN_W = VA_W - OFF_W;

  walk_state_e        state_q, state_d;
  logic [VA_W-1:0]    vaddr_q;
  logic [ASID_W-1:0]  asid_q;
  logic [VA_W-1:0]    tbase_q;
  logic [PN_W-1:0]    leaf_pn_q;
  logic               leaf_glob_q;

  logic               rsp_present, rsp_global;
  logic [PN_W-1:0]    rsp_pn;
  logic [IDX_W-1:0]   lvl_idx;
  logic               accept;

  assign accept  = (state_q == ST_IDLE) && miss_valid_i;
  assign lvl_idx = (state_q == ST_L1_REQ) ? vaddr_q[VA_W-1 -: IDX_W]
                                          : vaddr_q[OFF_W +: IDX_W];

  pw_entry_addr #(.ADDR_W(VA_W), .IDX_W(IDX_W)) u_addr (
    .table_base_i (tbase_q),
    .idx_i        (lvl_idx),
    .entry_addr_o (mem_req_addr_o)
  );

  pw_pte_decode #(.PTE_W(VA_W), .OFF_W(OFF_W), .PRES_B(PRESENT_BIT),
                  .GLOB_B(GLOBAL_BIT)) u_rsp_dec (
    .pte_i     (mem_rsp_data_i),
    .present_o (rsp_present),
    .global_o  (rsp_global),
    .pn_o      (rsp_pn)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (miss_valid_i) state_d = ST_L1_REQ;
      ST_L1_REQ:  if (mem_req_ready_i) state_d = ST_L1_WAIT;
      ST_L1_WAIT: if (mem_rsp_valid_i) state_d = rsp_present ? ST_L2_REQ : ST_FAULT;
      ST_L2_REQ:  if (mem_req_ready_i) state_d = ST_L2_WAIT;
      ST_L2_WAIT: if (mem_rsp_valid_i) state_d = rsp_present ? ST_FILL : ST_FAULT;
      ST_FILL:    state_d = ST_IDLE;
      ST_FAULT:   state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      vaddr_q     <= '0;
      asid_q      <= '0;
      tbase_q     <= '0;
      leaf_pn_q   <= '0;
      leaf_glob_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        vaddr_q <= miss_vaddr_i;
        asid_q  <= miss_asid_i;
        tbase_q <= base_i;
      end
      if (state_q == ST_L1_WAIT && mem_rsp_valid_i && rsp_present)
        tbase_q <= {rsp_pn, {OFF_W{1'b0}}};
      if (state_q == ST_L2_WAIT && mem_rsp_valid_i && rsp_present) begin
        leaf_pn_q   <= rsp_pn;
        leaf_glob_q <= rsp_global;
      end
    end
  end

  assign busy_o          = (state_q != ST_IDLE);
  assign mem_req_valid_o = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
  assign fill_valid_o    = (state_q == ST_FILL);
  assign retry_o         = (state_q == ST_FILL);
  assign fill_vpn_o      = vaddr_q[VA_W-1:OFF_W];
  assign fill_pfn_o      = leaf_pn_q;
  assign fill_asid_o     = asid_q;
  assign fill_global_o   = leaf_glob_q;
  assign fault_o         = (state_q == ST_FAULT);
  assign fault_vaddr_o   = vaddr_q;

  // R2
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_valid_i && !busy_o) |=> busy_o);
  // R4
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));
  // R6
  fill_after_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fill_valid_o) |-> $past(mem_rsp_valid_i));
  // R6
  fill_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_o |=> (!fill_valid_o && !busy_o));
  // R7
  fault_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> (!fault_o && !busy_o));
  // R9
  fill_fault_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fill_valid_o && fault_o));
  // R10
  req_when_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> busy_o);
endmodule

// File: tb/page_walker_tb_top.sv
`timescale 1ns/1ps
module page_walker_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [31:0] base_i;
  logic        miss_valid_i;
  logic [31:0] miss_vaddr_i;
  logic [7:0]  miss_asid_i;
  logic        busy_o, mem_req_valid_o, mem_req_ready_i, mem_rsp_valid_i;
  logic [31:0] mem_req_addr_o, mem_rsp_data_i;
  logic        fill_valid_o, fill_global_o, retry_o, fault_o;
  logic [19:0] fill_vpn_o, fill_pfn_o;
  logic [7:0]  fill_asid_o;
  logic [31:0] fault_vaddr_o;

  page_walker dut_i (.*);

  always #2.5 clk_i = ~clk_i;

  int total = 0, bad = 0;
  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  // memory model state
  logic [31:0] l1_addr, l1_data, l2_addr, l2_data;
  int          stall_n = 0, rsp_lat = 0;
  logic [31:0] rd_addr [4];
  int          n_rd = 0, hold_err = 0, rsp_cyc = 0;

  // monitor state
  int          n_fill = 0, n_fault = 0, fill_cyc = 0, fault_cyc = 0;
  int          retry_mis = 0, idle_req = 0;
  logic [19:0] m_vpn, m_pfn;
  logic [7:0]  m_asid;
  logic        m_glob;
  logic [31:0] m_fva;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    mem_req_ready_i = 1'b0;
    mem_rsp_valid_i = 1'b0;
    mem_rsp_data_i  = '0;
    forever begin
      @(negedge clk_i);
      mem_rsp_valid_i = 1'b0;
      if (mem_req_valid_o && rst_ni) begin
        logic [31:0] a0;
        a0 = mem_req_addr_o;
        for (int s = 0; s < stall_n; s++) begin
          mem_req_ready_i = 1'b0;
          @(negedge clk_i);
          if (!mem_req_valid_o || mem_req_addr_o != a0) hold_err++;
        end
        mem_req_ready_i = 1'b1;
        if (n_rd < 4) rd_addr[n_rd] = mem_req_addr_o;
        n_rd++;
        @(negedge clk_i);
        mem_req_ready_i = 1'b0;
        for (int s = 0; s < rsp_lat; s++) @(negedge clk_i);
        if (a0 == l1_addr)      mem_rsp_data_i = l1_data;
        else if (a0 == l2_addr) mem_rsp_data_i = l2_data;
        else                    mem_rsp_data_i = 32'h0;
        mem_rsp_valid_i = 1'b1;
        rsp_cyc = cyc;
      end
    end
  end

  always @(negedge clk_i) begin
    if (retry_o !== fill_valid_o) retry_mis++;
    if (mem_req_valid_o && !busy_o) idle_req++;
    if (fill_valid_o) begin
      n_fill++; fill_cyc = cyc;
      m_vpn = fill_vpn_o; m_pfn = fill_pfn_o; m_asid = fill_asid_o; m_glob = fill_global_o;
    end
    if (fault_o) begin
      n_fault++; fault_cyc = cyc; m_fva = fault_vaddr_o;
    end
  end

  // kind: 0 success, 1 fault at level 1, 2 fault at level 2
  task automatic run_walk(input logic [31:0] va, input logic [7:0] asid, input logic [31:0] base,
                          input logic [31:0] pte1, input logic [31:0] pte2,
                          input int stall, input int lat, input bit disturb, input string tag);
    int kind;
    kind = !pte1[0] ? 1 : (!pte2[0] ? 2 : 0);
    l1_addr = base + {20'h0, va[31:22], 2'b00};
    l2_addr = {pte1[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
    l1_data = pte1; l2_data = pte2;
    stall_n = stall; rsp_lat = lat;
    n_rd = 0; hold_err = 0; n_fill = 0; n_fault = 0;
    @(negedge clk_i);
    base_i = base; miss_vaddr_i = va; miss_asid_i = asid; miss_valid_i = 1'b1;
    @(negedge clk_i);
    miss_valid_i = 1'b0;
    chk(busy_o === 1'b1, {tag, " R2 busy after accept"}, busy_o, 1);
    if (disturb) begin
      base_i = base ^ 32'h0004_0000;
      miss_vaddr_i = ~va; miss_asid_i = ~asid; miss_valid_i = 1'b1;
      @(negedge clk_i);
      miss_valid_i = 1'b0;
    end
    for (int i = 0; i < 400 && busy_o; i++) @(negedge clk_i);
    chk(busy_o === 1'b0, {tag, " R9 busy drops"}, busy_o, 0);
    chk(hold_err == 0, {tag, " R4 request held"}, hold_err, 0);
    chk(n_rd >= 1 && rd_addr[0] == l1_addr, {tag, " R3 level-1 address"}, rd_addr[0], l1_addr);
    if (kind == 1) begin
      chk(n_rd == 1, {tag, " R7 single read"}, n_rd, 1);
      chk(n_fault == 1 && n_fill == 0, {tag, " R7 fault only"}, {n_fault[15:0], n_fill[15:0]}, 32'h0001_0000);
      chk(m_fva == va, {tag, " R7 fault address"}, m_fva, va);
      chk(fault_cyc == rsp_cyc + 1, {tag, " R7 fault timing"}, fault_cyc, rsp_cyc + 1);
    end else begin
      chk(n_rd == 2 && rd_addr[1] == l2_addr, {tag, " R5 level-2 address"}, rd_addr[1], l2_addr);
      if (kind == 2) begin
        chk(n_fault == 1 && n_fill == 0, {tag, " R8 fault only"}, {n_fault[15:0], n_fill[15:0]}, 32'h0001_0000);
        chk(m_fva == va, {tag, " R8 fault address"}, m_fva, va);
        chk(fault_cyc == rsp_cyc + 1, {tag, " R8 fault timing"}, fault_cyc, rsp_cyc + 1);
      end else begin
        chk(n_fill == 1 && n_fault == 0, {tag, " R9 fill only"}, {n_fill[15:0], n_fault[15:0]}, 32'h0001_0000);
        chk(fill_cyc == rsp_cyc + 1, {tag, " R6 fill timing"}, fill_cyc, rsp_cyc + 1);
        chk(m_vpn == va[31:12], {tag, " R6 vpn"}, m_vpn, va[31:12]);
        chk(m_pfn == pte2[31:12], {tag, " R6 pfn"}, m_pfn, pte2[31:12]);
        chk(m_asid == asid, {tag, " R6 asid"}, m_asid, asid);
        chk(m_glob == pte2[8], {tag, " R6 global"}, m_glob, pte2[8]);
      end
    end
    chk(retry_mis == 0, {tag, " R6 retry with fill"}, retry_mis, 0);
    chk(idle_req == 0, {tag, " R10 no idle request"}, idle_req, 0);
  endtask

  task automatic test_reset();
    @(negedge clk_i);
    chk(busy_o === 1'b0, "R1 busy", busy_o, 0);
    chk(mem_req_valid_o === 1'b0, "R1 req", mem_req_valid_o, 0);
    chk(fill_valid_o === 1'b0 && retry_o === 1'b0, "R1 fill", fill_valid_o, 0);
    chk(fault_o === 1'b0, "R1 fault", fault_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_ni = 1'b0; base_i = '0; miss_valid_i = 1'b0; miss_vaddr_i = '0; miss_asid_i = '0;
    test_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    test_reset();
    run_walk(32'h1234_5678, 8'h11, 32'h0010_0000, 32'h0020_0001, 32'h0ABC_D001, 0, 0, 0, "basic");
    run_walk(32'hFFC0_1ABC, 8'hA5, 32'h0030_0000, 32'h0044_4001, 32'h7777_7101, 3, 2, 0, "stall_global");
    run_walk(32'h8040_3000, 8'h02, 32'h0050_0000, 32'h0060_0000, 32'h1111_1001, 0, 1, 0, "l1_fault");
    run_walk(32'h0000_0FFF, 8'h03, 32'h0070_0000, 32'h0080_0101, 32'h2222_2100, 2, 0, 0, "l2_fault");
    run_walk(32'h4567_89AB, 8'h5C, 32'h0090_0000, 32'h00A0_0001, 32'h3333_3001, 4, 3, 1, "busy_ignore");
    run_walk(32'h0040_1000, 8'h77, 32'h00B0_0000, 32'h00C0_0001, 32'hFFFF_F101, 0, 0, 0, "back_to_back");
    summary();
  end
endmodule